// File: doc/BRIEF.md
# Four-Phase Asynchronous Bus Target

This block is a clocked target for a simple asynchronous parallel bus. A master opens a transfer by pulling the active-low select line low. While select stays low, a 16-bit address, a read/not-write flag and an 8-bit write byte are held steady. The target passes select and the direction flag through a two-flop synchroniser. It waits one more clock so that the address and data have settled, and then serves the access from a small byte-wide storage array. It reports completion by pulling its active-low done line low, and releases done only after the master has raised select again. This completes a four-phase, return-to-idle handshake.

The storage covers the lowest part of the address space, 256 bytes by default. Accesses above that range still complete the handshake. Reads there return all ones and writes there leave the storage untouched. An active-low bus reset clears the storage and the read-data register and returns the handshake to idle.

Top module: `abus_target`

## Requirements
- R1: While and after bus reset, done_n is 1, rdata is 8'h00, and every storage byte reads back as 8'h00.
- R2: A write transfer (rd_wrn = 0) stores wdata at the addressed byte, and a later read (rd_wrn = 1) of that address returns it.
- R3: On a read, rdata already holds the addressed byte in the first cycle that done_n is low. rdata stays unchanged from then until done_n returns high.
- R4: Once done_n is low, it stays low for as long as sel_n stays low. After sel_n rises, done_n returns high within a bounded number of clocks (three rising edges).
- R5: A write updates its byte exactly once per transfer, even if select is held low for many clocks. A new access is accepted only while done_n is high, after both lines have returned high.
- R6: A read transfer leaves the storage unchanged.
- R7: A read at an address at or above the storage depth (256) returns 8'hFF, and the handshake completes normally.
- R8: A write at an address at or above the storage depth changes no storage byte (there is no aliasing onto low addresses), and the handshake completes normally.
- R9: A select pulse that stays low for only one clock is not accepted. done_n stays high and nothing is written, because an access needs the synchronised select to be low on two consecutive clocks.
- R10: Asserting bus reset in the middle of a transfer returns done_n high and clears rdata at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| bus_rst_n | input | 1 | Active-low asynchronous bus reset |
| sel_n | input | 1 | Active-low transfer select from the master |
| rd_wrn | input | 1 | 1 = read, 0 = write; valid while sel_n is low |
| addr | input | 16 | Byte address; valid while sel_n is low |
| wdata | input | 8 | Write byte; valid while sel_n is low |
| rdata | output | 8 | Read byte; valid when done_n falls on a read |
| done_n | output | 1 | Active-low completion |

## Verification
The hardest condition to reach from the ports is a select pulse short enough to pass the synchroniser but too short to be accepted. The bench makes it by driving sel_n low on one falling edge and raising it on the next, so exactly one rising edge samples it low. A second hard case is a write whose select is held low long after completion while the write byte is deliberately changed. A target that wrote more than once would then store the wrong byte, and a later read exposes it. A full sweep of all 256 bytes and a set of high addresses cover the storage and the out-of-range path.

// File: rtl/abus_pkg.sv
package abus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_ACCESS = 2'd2,
    ST_DONE   = 2'd3
  } hs_state_t;

  // True when a byte address falls inside the implemented storage.
  function automatic logic addr_hit(input logic [31:0] a, input int unsigned depth);
    return a < 32'(depth);
  endfunction

endpackage

// File: rtl/abus_sync.sv
module abus_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/abus_fsm.sv
module abus_fsm
  import abus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_low,
  output logic access_stb,
  output logic done_n
);
  hs_state_t state;
  logic      done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      done_q <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE:   if (sel_low) state <= ST_SETTLE;
        ST_SETTLE: state <= sel_low ? ST_ACCESS : ST_IDLE;
        ST_ACCESS: begin
          state  <= ST_DONE;
          done_q <= 1'b0;
        end
        ST_DONE: if (!sel_low) begin
          state  <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign access_stb = (state == ST_ACCESS);
  assign done_n     = done_q;
endmodule

// File: rtl/abus_store.sv
module abus_store
  import abus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              access_stb,
  input  logic              rnw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              wr_stb
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              hit;
  logic [IDX_W-1:0]  idx;

  assign hit    = addr_hit(32'(addr), DEPTH);
  assign idx    = addr[IDX_W-1:0];
  assign wr_stb = access_stb && !rnw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else if (access_stb) begin
      if (rnw) begin
        rdata <= hit ? mem[idx] : '1;
      end else if (hit) begin
        mem[idx] <= wdata;
      end
    end
  end
endmodule

// File: rtl/abus_target.sv
module abus_target #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int MEM_DEPTH = 256
) (
  input  logic              clk,
  input  logic              bus_rst_n,
  input  logic              sel_n,
  input  logic              rd_wrn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done_n
);
  logic [1:0] strobes_s;
  logic       sel_low;
  logic       rnw_s;
  logic       access_stb;
  logic       wr_stb;

  abus_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (bus_rst_n),
    .d     ({sel_n, rd_wrn}),
    .q     (strobes_s)
  );

  assign sel_low = !strobes_s[1];
  assign rnw_s   = strobes_s[0];

  abus_fsm u_fsm (
    .clk        (clk),
    .rst_n      (bus_rst_n),
    .sel_low    (sel_low),
    .access_stb (access_stb),
    .done_n     (done_n)
  );

  abus_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(MEM_DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (bus_rst_n),
    .access_stb (access_stb),
    .rnw        (rnw_s),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .wr_stb     (wr_stb)
  );
endmodule

// File: rtl/abus_target_chk.sv
module abus_target_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              bus_rst_n,
  input logic              done_n,
  input logic [DATA_W-1:0] rdata,
  input logic              sel_low,
  input logic              access_stb,
  input logic              wr_stb
);
  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!bus_rst_n)
    (!done_n && $past(!done_n)) |-> $stable(rdata));

  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (!bus_rst_n)
    (!done_n && sel_low) |=> !done_n);

  // R5
  one_write_chk: assert property (@(posedge clk) disable iff (!bus_rst_n)
    wr_stb |=> (!wr_stb && !done_n));

  // R5
  accept_idle_chk: assert property (@(posedge clk) disable iff (!bus_rst_n)
    access_stb |-> done_n);

  // R9
  settle_chk: assert property (@(posedge clk) disable iff (!bus_rst_n)
    access_stb |-> (sel_low && $past(sel_low)));
endmodule

bind abus_target abus_target_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .bus_rst_n  (bus_rst_n),
  .done_n     (done_n),
  .rdata      (rdata),
  .sel_low    (sel_low),
  .access_stb (access_stb),
  .wr_stb     (wr_stb)
);

// File: tb/abus_target_test.sv
module abus_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        bus_rst_n = 1'b0;
  logic        sel_n = 1'b1;
  logic        rd_wrn = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        done_n;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  abus_target uut (
    .clk(clk), .bus_rst_n(bus_rst_n), .sel_n(sel_n), .rd_wrn(rd_wrn),
    .addr(addr), .wdata(wdata), .rdata(rdata), .done_n(done_n)
  );

  function automatic logic [7:0] pattern(input int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // One full handshake; hold = extra cycles select stays low after done falls.
  task automatic xfer(input logic rnw, input logic [15:0] a, input logic [7:0] wd,
                      input int hold, output logic [7:0] rd);
    int n;
    bit stable_ok;
    @(negedge clk);
    rd_wrn = rnw; addr = a; wdata = wd; sel_n = 1'b0;
    n = 0;
    while (done_n && n < 30) begin @(negedge clk); n++; end
    if (done_n) check(1'b0, "R4 done never fell", 16'(done_n), 16'h0);
    rd = rdata;
    stable_ok = 1;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (done_n !== 1'b0 || rdata !== rd) stable_ok = 0;
      wdata = ~wd;
    end
    if (hold > 0) check(stable_ok, "R4/R3 done or rdata moved while held", 16'(rdata), 16'(rd));
    sel_n = 1'b1;
    n = 0;
    while (!done_n && n < 30) begin
      if (rdata !== rd) stable_ok = 0;
      @(posedge clk); n++;
      #1;
    end
    if (n > 3 || done_n !== 1'b1)
      check(1'b0, "R4 release latency", 16'(n), 16'd3);
    if (!stable_ok) check(1'b0, "R3 rdata unstable while done low", 16'(rdata), 16'(rd));
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 16'h0, 16'h1);
    summary();
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done_n === 1'b1, "R1 done_n in reset", 16'(done_n), 16'h1);
    check(rdata === 8'h00, "R1 rdata in reset", 16'(rdata), 16'h0);
    bus_rst_n = 1'b1;
    @(negedge clk);
    check(done_n === 1'b1, "R1 done_n after reset", 16'(done_n), 16'h1);
    xfer(1'b1, 16'd5, 8'h00, 0, r);
    check(r === 8'h00, "R1 storage cleared", 16'(r), 16'h0);

    // R2 write sweep, R3 read sweep
    for (int a = 0; a < DEPTH; a++) xfer(1'b0, 16'(a), pattern(a), 0, r);
    for (int a = 0; a < DEPTH; a++) begin
      xfer(1'b1, 16'(a), 8'h00, 0, r);
      check(r === pattern(a), "R2/R3 readback", 16'(r), 16'(pattern(a)));
    end
    // R6 reads leave storage unchanged: second sweep
    for (int a = 0; a < DEPTH; a += 17) begin
      xfer(1'b1, 16'(a), 8'h00, 0, r);
      check(r === pattern(a), "R6 re-read", 16'(r), 16'(pattern(a)));
    end

    // R5 long-held write with changing wdata stores once
    xfer(1'b0, 16'd40, 8'hC3, 25, r);
    xfer(1'b1, 16'd40, 8'h00, 0, r);
    check(r === 8'hC3, "R5 single write", 16'(r), 16'hC3);
    // R4 long-held read keeps done and data
    xfer(1'b1, 16'd41, 8'h00, 30, r);
    check(r === pattern(41), "R4 held read", 16'(r), 16'(pattern(41)));

    // R7 out-of-range reads
    xfer(1'b1, 16'h0100, 8'h00, 0, r);
    check(r === 8'hFF, "R7 read 0x0100", 16'(r), 16'hFF);
    xfer(1'b1, 16'h8000, 8'h00, 0, r);
    check(r === 8'hFF, "R7 read 0x8000", 16'(r), 16'hFF);
    xfer(1'b1, 16'hFFFF, 8'h00, 2, r);
    check(r === 8'hFF, "R7 read 0xFFFF", 16'(r), 16'hFF);

    // R8 out-of-range writes, no aliasing
    for (int k = 0; k < 8; k++) xfer(1'b0, 16'(16'h0100 * (k + 1) + k), 8'h5A, 0, r);
    xfer(1'b0, 16'hFFFF, 8'h5A, 0, r);
    for (int k = 0; k < 8; k++) begin
      xfer(1'b1, 16'(k), 8'h00, 0, r);
      check(r === pattern(k), "R8 no alias", 16'(r), 16'(pattern(k)));
    end
    xfer(1'b1, 16'hFF, 8'h00, 0, r);
    check(r === pattern(255), "R8 top byte intact", 16'(r), 16'(pattern(255)));

    // R9 one-clock select glitch is rejected
    @(negedge clk);
    rd_wrn = 1'b0; addr = 16'd7; wdata = 8'hE1; sel_n = 1'b0;
    @(negedge clk);
    sel_n = 1'b1;
    begin
      bit quiet = 1;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (done_n !== 1'b1) quiet = 0;
      end
      check(quiet, "R9 glitch raised done", 16'(done_n), 16'h1);
    end
    xfer(1'b1, 16'd7, 8'h00, 0, r);
    check(r === pattern(7), "R9 glitch wrote", 16'(r), 16'(pattern(7)));

    // R10 reset mid-transfer
    @(negedge clk);
    rd_wrn = 1'b1; addr = 16'd3; sel_n = 1'b0;
    repeat (6) @(negedge clk);
    check(done_n === 1'b0 && rdata === pattern(3), "R10 pre-reset read", 16'(rdata), 16'(pattern(3)));
    bus_rst_n = 1'b0;
    #1;
    check(done_n === 1'b1, "R10 done_n after reset", 16'(done_n), 16'h1);
    check(rdata === 8'h00, "R10 rdata after reset", 16'(rdata), 16'h0);
    @(negedge clk);
    sel_n = 1'b1;
    @(negedge clk);
    bus_rst_n = 1'b1;
    @(negedge clk);
    xfer(1'b1, 16'd3, 8'h00, 0, r);
    check(r === 8'h00, "R1 storage cleared by reset", 16'(r), 16'h0);

    summary();
  end
endmodule